// File: doc/BRIEF.md
# Maskable Trigger Word Comparator Slice

This block is one 16-channel slice of a logic-analyzer trigger. Each sample word is tested against a configured pattern. Every channel has a polarity bit and a don't-care bit. A channel matches when its level equals the polarity it was given, or when its don't-care bit is set. The slice reports a single qualify bit, which is true only when every channel matches. A wider analyzer places several slices side by side and ANDs their qualify outputs. For example, two slices give 32 channels.

The host loads the configuration serially, one bit per shift strobe, into a 32-bit chain. A separate load strobe then copies the whole chain into shadow registers in a single cycle. The comparator therefore never works from a half-written pattern.

The slice also contains a small readback path. It returns one byte of a 16-bit captured memory word to the host, and the host chooses which byte.

Samples arrive on a valid/ready stream, and qualify results leave on a second valid/ready stream. The output stage holds one result. A new sample is accepted only when that stage is empty or is being drained in the same cycle. While `q_valid` is high and `q_ready` is low, `s_ready` stays low and incoming samples wait upstream. Configuration and readback pins are plain level and strobe signals with no handshake.

Top module: `trig_word_slice`

## Requirements
- R1: After reset, every don't-care bit is 1 and every polarity bit is 0, `q_valid` is 0 and `s_ready` is 1. Any sample accepted before the first load therefore yields `q_hit` = 1.
- R2: On each rising clock edge with `cfg_shift` = 1, the 32-bit chain shifts by one place and takes `cfg_sdi`. After 32 shifts, the first bit shifted in is polarity bit 15, followed by polarity bits 14 down to 0, then don't-care bits 15 down to 0. An edge with `cfg_load` = 1 makes that content the active configuration.
- R3: Shifting without `cfg_load` leaves the active configuration, and therefore every qualify result, unchanged.
- R4: Polarity bit 0 means the channel matches when its input is 1. Polarity bit 1 means the channel matches when its input is 0.
- R5: A channel whose don't-care bit is 1 always matches. When all don't-care bits are 1, `q_hit` is 1 for every sample.
- R6: `q_hit` is 1 exactly when all 16 channels match.
- R7: A sample accepted on an edge gives `q_valid` = 1 after that edge. While `q_valid` = 1 and `q_ready` = 0, `q_valid` stays 1 and `q_hit` holds its value.
- R8: `s_ready` is 1 exactly when the output stage is empty or `q_ready` = 1. A sample presented while `s_ready` = 0 is not taken, and results leave in the order their samples were accepted.
- R9: `rd_byte` shows `rd_word[7:0]` when `rd_sel` = 0 and `rd_word[15:8]` when `rd_sel` = 1, with no clock delay.
- R10: If `cfg_load` and `cfg_shift` are both 1 on the same edge, the load takes the chain content from before that edge's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sdi | input | 1 | Serial configuration bit |
| cfg_shift | input | 1 | Shift strobe for the configuration chain |
| cfg_load | input | 1 | Copies the chain into the active configuration |
| s_valid | input | 1 | Sample word is present |
| s_ready | output | 1 | Slice can accept a sample |
| s_data | input | 16 | Sample word, one bit per channel |
| q_valid | output | 1 | Qualify result is present |
| q_ready | input | 1 | Consumer takes the result |
| q_hit | output | 1 | Trigger word matched |
| rd_word | input | 16 | Captured memory word for readback |
| rd_sel | input | 1 | Byte select: 0 selects the low byte, 1 the high byte |
| rd_byte | output | 8 | Selected readback byte |

## Verification
The bench builds the slice with its defaults: 16 channels, 8-bit readback bytes and a 1-bit byte select. At this size a full 32-bit serial load takes only a few dozen cycles, so the bench can run several complete configurations. These include mixed polarity with partial don't-care, all channels cared for, and all channels don't-care. Between loads, the bench shifts partial or unloaded patterns to show that the active configuration does not move until a load arrives, and it drives a load on the same edge as a shift to check which chain content the load takes. Consumer back-pressure is applied on a repeating pattern, so stalls and in-order delivery occur alongside changing sample words.

// File: rtl/trig_slice_pkg.sv
package trig_slice_pkg;
  localparam int unsigned SLICE_CH_DEF = 16;
  localparam int unsigned RB_BYTE_W    = 8;

  // bits needed to index n items (never less than one)
  function automatic int unsigned idx_w(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/tws_cfg_chain.sv
module tws_cfg_chain #(
  parameter int unsigned CH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          sdi,
  input  logic          load,
  output logic [CH-1:0] inv_o,
  output logic [CH-1:0] care_n_o
);
  localparam int unsigned CHAIN_W = 2 * CH;

  logic [CHAIN_W-1:0] chain_q;

  // serial chain: first bit in ends at the top (polarity MSB)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= {{CH{1'b0}}, {CH{1'b1}}};
    end else if (shift_en) begin
      chain_q <= {chain_q[CHAIN_W-2:0], sdi};
    end
  end

  // shadow copy takes pre-shift contents
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_o    <= '0;
      care_n_o <= '1;
    end else if (load) begin
      inv_o    <= chain_q[CHAIN_W-1:CH];
      care_n_o <= chain_q[CH-1:0];
    end
  end
endmodule

// File: rtl/tws_qualify.sv
module tws_qualify #(
  parameter int unsigned CH = 16
) (
  input  logic [CH-1:0] data_i,
  input  logic [CH-1:0] inv_i,
  input  logic [CH-1:0] care_n_i,
  output logic          hit_o
);
  logic [CH-1:0] lane_ok;

  for (genvar g = 0; g < CH; g++) begin : g_lane
    logic pol_ok;
    assign pol_ok     = ~(data_i[g] ~^ inv_i[g]);
    assign lane_ok[g] = pol_ok | care_n_i[g];
  end

  assign hit_o = &lane_ok;
endmodule

// File: rtl/tws_byte_mux.sv
module tws_byte_mux #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned LANES = WORD_W / BYTE_W;

  logic [BYTE_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_o = lane[0];
    for (int i = 1; i < LANES; i++) begin
      if (sel_i == SEL_W'(i)) byte_o = lane[i];
    end
  end
endmodule

// File: rtl/trig_word_slice.sv
module trig_word_slice
  import trig_slice_pkg::*;
#(
  parameter int unsigned CH     = SLICE_CH_DEF,
  parameter int unsigned BYTE_W = RB_BYTE_W,
  parameter int unsigned SEL_W  = idx_w(CH / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sdi,
  input  logic              cfg_shift,
  input  logic              cfg_load,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [CH-1:0]     s_data,
  output logic              q_valid,
  input  logic              q_ready,
  output logic              q_hit,
  input  logic [CH-1:0]     rd_word,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [CH-1:0] inv_cfg;
  logic [CH-1:0] care_n_cfg;
  logic          hit_now;
  logic          take;

  tws_cfg_chain #(.CH(CH)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_shift),
    .sdi      (cfg_sdi),
    .load     (cfg_load),
    .inv_o    (inv_cfg),
    .care_n_o (care_n_cfg)
  );

  tws_qualify #(.CH(CH)) u_qual (
    .data_i   (s_data),
    .inv_i    (inv_cfg),
    .care_n_i (care_n_cfg),
    .hit_o    (hit_now)
  );

  tws_byte_mux #(.WORD_W(CH), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_rb (
    .word_i (rd_word),
    .sel_i  (rd_sel),
    .byte_o (rd_byte)
  );

  assign s_ready = !q_valid || q_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_hit   <= 1'b0;
    end else if (take) begin
      q_valid <= 1'b1;
      q_hit   <= hit_now;
    end else if (q_ready) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_word_slice_chk.sv
module trig_word_slice_chk #(
  parameter int unsigned CH     = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              s_valid,
  input logic              s_ready,
  input logic              q_valid,
  input logic              q_ready,
  input logic              q_hit,
  input logic [CH-1:0]     rd_word,
  input logic [SEL_W-1:0]  rd_sel,
  input logic [BYTE_W-1:0] rd_byte,
  input logic [CH-1:0]     inv_cfg,
  input logic [CH-1:0]     care_n_cfg
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> (q_valid && $stable(q_hit)));

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> q_valid);

  // R8
  ready_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> (q_valid && !q_ready));

  // R3
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(inv_cfg) && $stable(care_n_cfg)));

  // R5
  all_dont_care_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&care_n_cfg) && s_valid && s_ready) |=> q_hit);

  // R9
  readback_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_byte == rd_word[rd_sel*BYTE_W +: BYTE_W]);
endmodule

bind trig_word_slice trig_word_slice_chk #(
  .CH(CH), .BYTE_W(BYTE_W), .SEL_W(SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .q_valid    (q_valid),
  .q_ready    (q_ready),
  .q_hit      (q_hit),
  .rd_word    (rd_word),
  .rd_sel     (rd_sel),
  .rd_byte    (rd_byte),
  .inv_cfg    (inv_cfg),
  .care_n_cfg (care_n_cfg)
);

// File: tb/trig_word_slice_tb_top.sv
module trig_word_slice_tb_top;
  localparam int CH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_sdi = 1'b0, cfg_shift = 1'b0, cfg_load = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [CH-1:0] s_data = '0;
  logic          q_valid;
  logic          q_ready = 1'b1;
  logic          q_hit;
  logic [CH-1:0] rd_word = '0;
  logic [0:0]    rd_sel = 1'b0;
  logic [7:0]    rd_byte;

  always #2.5 clk = ~clk;

  trig_word_slice dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sdi(cfg_sdi), .cfg_shift(cfg_shift),
    .cfg_load(cfg_load), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .q_valid(q_valid), .q_ready(q_ready), .q_hit(q_hit),
    .rd_word(rd_word), .rd_sel(rd_sel), .rd_byte(rd_byte)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int n_sent   = 0;
  int n_recv   = 0;
  bit bp_on    = 1'b0;
  int bp_cnt   = 0;

  logic [CH-1:0] m_inv  = '0;
  logic [CH-1:0] m_care = '1;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic model_hit(input logic [CH-1:0] d);
    return &((d ^ m_inv) | m_care);
  endfunction

  // consumer back-pressure pattern
  initial forever begin
    @(negedge clk);
    q_ready = bp_on ? ((bp_cnt % 3) != 0) : 1'b1;
    bp_cnt++;
  end

  // monitor: samples 1 ns after the falling edge
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && q_valid && q_ready) begin
      item_t it;
      n_recv++;
      if (sb_q.size() == 0) check(1'b0, "R8 unexpected result", 1, 0);
      else begin
        it = sb_q.pop_front();
        check(q_hit === it.exp, it.tag, q_hit, it.exp);
      end
    end
  end

  task automatic send(input logic [CH-1:0] d, input string tag);
    bit done;
    done = 1'b0;
    while (!done) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = d;
      #1;
      if (s_ready) begin
        item_t it;
        it.exp = model_hit(d);
        it.tag = tag;
        sb_q.push_back(it);
        n_sent++;
        done = 1'b1;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic shift_pattern(input logic [CH-1:0] inv, input logic [CH-1:0] care);
    logic [2*CH-1:0] bits;
    bits = {inv, care};
    for (int i = 2*CH-1; i >= 0; i--) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_sdi   = bits[i];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
  endtask

  task automatic load_now(input logic [CH-1:0] inv, input logic [CH-1:0] care);
    @(negedge clk);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_inv  = inv;
    m_care = care;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && sb_q.size() != 0; i++) @(negedge clk);
    check(sb_q.size() == 0, "R8 results outstanding", sb_q.size(), 0);
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(q_valid == 1'b0, "R1 q_valid after reset", q_valid, 0);
    check(s_ready == 1'b1, "R1 s_ready after reset", s_ready, 1);
    send(16'h0000, "R1 default all dont-care");
    send(16'hFFFF, "R1 default all dont-care");

    // R7 latency: result present one edge after acceptance
    @(negedge clk);
    s_valid = 1'b1; s_data = 16'h1234;
    sb_q.push_back('{exp: 1'b1, tag: "R7 latency value"});
    n_sent++;
    @(negedge clk);
    s_valid = 1'b0;
    #0.5;
    check(q_valid == 1'b1, "R7 q_valid after accept", q_valid, 1);
    drain();

    // R2/R4/R5/R6: mixed polarity, high byte don't-care
    shift_pattern(16'h00F0, 16'hFF00);
    load_now(16'h00F0, 16'hFF00);
    send(16'h000F, "R4 polarity match");
    send(16'hAB0F, "R5 masked channels ignored");
    send(16'h001F, "R4 inverted channel high");
    send(16'h000E, "R6 one channel miss");
    drain();

    // R6: every channel cared, positive polarity
    shift_pattern(16'h0000, 16'h0000);
    load_now(16'h0000, 16'h0000);
    send(16'hFFFF, "R6 all ones hit");
    send(16'hFFFE, "R6 single bit miss");
    send(16'h7FFF, "R2 msb channel cared");
    drain();

    // R3: shift new pattern without load
    shift_pattern(16'hFFFF, 16'h0000);
    send(16'hFFFF, "R3 unloaded shift ignored");
    send(16'h0000, "R3 unloaded shift ignored");
    drain();

    // R10: load on the same edge as one more shift
    @(negedge clk);
    cfg_shift = 1'b1; cfg_sdi = 1'b1; cfg_load = 1'b1;
    @(negedge clk);
    cfg_shift = 1'b0; cfg_load = 1'b0;
    m_inv = 16'hFFFF; m_care = 16'h0000;
    send(16'h0000, "R10 load takes pre-shift chain");
    send(16'hFFFF, "R10 load takes pre-shift chain");
    send(16'h0001, "R4 all inverted miss");
    drain();

    // R8/R7: back-pressure with varied data
    shift_pattern(16'h0F0F, 16'hC003);
    load_now(16'h0F0F, 16'hC003);
    bp_on = 1'b1;
    for (int i = 0; i < 24; i++) begin
      logic [CH-1:0] d;
      d = (i % 4 == 0) ? 16'h30F0 : 16'(i * 16'h1357 + 16'h0A5C);
      send(d, "R8 ordered under back-pressure");
    end
    for (int i = 0; i < 60 && sb_q.size() != 0; i++) @(negedge clk);
    bp_on = 1'b0;
    drain();
    check(n_sent == n_recv, "R8 sent equals received", n_recv, n_sent);

    // R5: all dont-care with polarity set
    shift_pattern(16'hA5A5, 16'hFFFF);
    load_now(16'hA5A5, 16'hFFFF);
    send(16'h0000, "R5 all dont-care");
    send(16'h5A5A, "R5 all dont-care");
    drain();

    // R9 readback
    @(negedge clk);
    rd_word = 16'hA55A; rd_sel = 1'b0;
    #1;
    check(rd_byte == 8'h5A, "R9 low byte", rd_byte, 8'h5A);
    rd_sel = 1'b1;
    #1;
    check(rd_byte == 8'hA5, "R9 high byte", rd_byte, 8'hA5);
    rd_word = 16'h3C81;
    #1;
    check(rd_byte == 8'h3C, "R9 follows word", rd_byte, 8'h3C);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule